// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a serial test access port of the IEEE 1149.1 kind. It is clocked by a test clock and steered by a mode-select line through the standard sixteen-state controller. A 3-bit instruction register chooses which data register sits between the serial input and the serial output. The choices are a one-bit bypass cell, a 32-bit identification word, or a boundary register whose cells capture a parallel vector of pin values.

The instruction set is kept small. There are two boundary instructions: one for external test and one for sampling. The sampling instruction has no preload function, so passing through the data-update state changes nothing. There is one identification instruction and one bypass instruction. Every unassigned code falls back to the bypass path. Power-on reset, or any visit to the reset state, selects the identification instruction. Serial output is launched on the falling test-clock edge and is marked valid only while a shift state is active. Driving the device pins from scan data is not part of this block.

Top module: `tap_port`

## Requirements
- R1: Five consecutive rising edges of `tck` with `tms` high bring the controller to the reset state from any state. Afterwards the active instruction is identification, and a data scan returns the identification word.
- R2: After `por_n` is released, with no instruction loaded yet, the active instruction is identification (code 3'b001). The first data scan shifts the 32-bit identification word out least significant bit first.
- R3: In the instruction-capture state the instruction shift register loads 3'b001. The first bits shifted out of an instruction scan are therefore 1, 0, 0.
- R4: The active instruction changes only on the clock edge that leaves the instruction-update state, or while the controller is in reset. Instruction bits are shifted in LSB first.
- R5: The identification word is {revision[2:0]=001, depth[4:0]=01010, architecture[5:0]=000000, device[5:0]=100101, vendor[10:0]=00000110100, 1}, listed from bit 31 down to bit 0. Bit 0 is always 1.
- R6: The bypass instruction (3'b111) places a single cell between `tdi` and `tdo`. This cell captures 0, so a data scan returns 0 followed by the input stream delayed by one clock.
- R7: The unassigned codes 3'b010, 3'b011, 3'b101 and 3'b110 behave exactly like bypass.
- R8: The sample instruction (3'b100) captures `bnd_pins` into the boundary register, with cell 0 shifted out first. Data shifted in and then passed through the data-update state has no effect: the next capture again shows the pins.
- R9: The external-test instruction (3'b000) also selects the boundary register and captures `bnd_pins` the same way.
- R10: Boundary cells marked unbonded capture 1 whatever their pin value. By default only cell 8 is unbonded.
- R11: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high exactly in the half-cycles that follow a rising edge leaving the controller in a shift state (instruction or data), and `tdo` then carries the shift register's bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bnd_pins | input | BSR_LEN | Parallel values captured by the boundary cells |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` carries shift data |

## Verification
The assertions assume that `tms`, `tdi` and `bnd_pins` settle well away from rising `tck`. They also assume `por_n` is asserted before the first edge, so the controller and the instruction register start from known values. The bench changes its inputs one nanosecond after each falling edge and holds the pins steady across every capture edge. Every scan starts from and returns to the idle state. The only departure from that pattern is the escape through five high `tms` edges in the middle of a data shift.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_t;

   typedef enum logic [1:0] {
      PATH_BYPASS,
      PATH_ID,
      PATH_BOUNDARY
   } dr_path_t;

   function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
      tap_state_t n;
      case (s)
         ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
#(
   parameter int RESET_RUN = 5
) (
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_t state
);
   localparam int CW = $clog2(RESET_RUN + 1);

   if (RESET_RUN != 5) begin : g_bad_run
      $error("RESET_RUN must equal the controller's escape length of 5");
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= ST_RESET;
      else        state <= tap_next(state, tms);
   end

   // checker-side count of consecutive high tms edges
   logic [CW-1:0] ones_cnt;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                          ones_cnt <= '0;
      else if (!tms)                       ones_cnt <= '0;
      else if (ones_cnt != CW'(RESET_RUN)) ones_cnt <= ones_cnt + 1'b1;
   end

   a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
      (ones_cnt == CW'(RESET_RUN)) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int                IR_W       = 3,
   parameter logic [IR_W-1:0]   INS_EXTEST = 3'b000,
   parameter logic [IR_W-1:0]   INS_IDCODE = 3'b001,
   parameter logic [IR_W-1:0]   INS_SAMPLE = 3'b100,
   parameter logic [IR_W-1:0]   INS_BYPASS = 3'b111
) (
   input  logic       tck,
   input  logic       por_n,
   input  logic       tdi,
   input  tap_state_t state,
   output logic       ir_so,
   output dr_path_t   path
);
   localparam logic [IR_W-1:0] CAP_VAL = IR_W'(2'b01);

   if (IR_W < 2) begin : g_bad_width
      $error("IR_W must be at least 2");
   end
   if (INS_IDCODE == INS_BYPASS || INS_IDCODE == INS_EXTEST ||
       INS_IDCODE == INS_SAMPLE || INS_EXTEST == INS_BYPASS ||
       INS_SAMPLE == INS_BYPASS) begin : g_bad_codes
      $error("instruction codes must be distinct");
   end

   logic [IR_W-1:0] ir_sr, ir_act;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sr <= CAP_VAL;
      end else if (state == ST_CAP_IR) begin
         ir_sr <= CAP_VAL;
      end else if (state == ST_SH_IR) begin
         ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                  ir_act <= INS_IDCODE;
      else if (state == ST_RESET)  ir_act <= INS_IDCODE;
      else if (state == ST_UPD_IR) ir_act <= ir_sr;
   end

   assign ir_so = ir_sr[0];

   always_comb begin
      if (ir_act == INS_IDCODE)
         path = PATH_ID;
      else if (ir_act == INS_EXTEST || ir_act == INS_SAMPLE)
         path = PATH_BOUNDARY;
      else
         path = PATH_BYPASS;
   end

   a_r2_reset_selects_id: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_RESET) |=> (ir_act == INS_IDCODE));

   a_r3_capture_value: assert property (@(posedge tck) disable iff (!por_n)
      ($past(state) == ST_CAP_IR) |-> (ir_sr == CAP_VAL));

   a_r4_update_only: assert property (@(posedge tck) disable iff (!por_n)
      (ir_act != $past(ir_act)) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int                  BSR_LEN  = 16,
   parameter logic [BSR_LEN-1:0]  UNBONDED = 16'h0100,
   parameter logic [31:0]         ID_VALUE = 32'h1
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tdi,
   input  tap_state_t         state,
   input  dr_path_t           path,
   input  logic [BSR_LEN-1:0] bnd_pins,
   output logic               dr_so
);
   if (BSR_LEN < 2) begin : g_bad_len
      $error("BSR_LEN must be at least 2");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("identification word must end in 1");
   end

   logic               byp;
   logic [31:0]        id_sr;
   logic [BSR_LEN-1:0] bsr;

   wire cap  = (state == ST_CAP_DR);
   wire shft = (state == ST_SH_DR);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                             byp <= 1'b0;
      else if (cap)                           byp <= 1'b0;
      else if (shft && path == PATH_BYPASS)   byp <= tdi;
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                        id_sr <= ID_VALUE;
      else if (cap)                      id_sr <= ID_VALUE;
      else if (shft && path == PATH_ID)  id_sr <= {tdi, id_sr[31:1]};
   end

   for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
      logic cap_v, sh_in;
      if (UNBONDED[i]) begin : g_fixed
         assign cap_v = 1'b1;
      end else begin : g_pin
         assign cap_v = bnd_pins[i];
      end
      if (i == BSR_LEN - 1) begin : g_head
         assign sh_in = tdi;
      end else begin : g_link
         assign sh_in = bsr[i+1];
      end
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)                              bsr[i] <= 1'b0;
         else if (cap)                            bsr[i] <= cap_v;
         else if (shft && path == PATH_BOUNDARY)  bsr[i] <= sh_in;
      end
   end

   always_comb begin
      case (path)
         PATH_ID:       dr_so = id_sr[0];
         PATH_BOUNDARY: dr_so = bsr[0];
         default:       dr_so = byp;
      endcase
   end

   a_r6_bypass_delay: assert property (@(posedge tck) disable iff (!por_n)
      (shft && path == PATH_BYPASS) |=> (byp == $past(tdi)));

   a_r10_unbonded_one: assert property (@(posedge tck) disable iff (!por_n)
      ($past(state) == ST_CAP_DR) |-> ((bsr & UNBONDED) == UNBONDED));

endmodule

// File: rtl/tap_port.sv
module tap_port
   import tap_pkg::*;
#(
   parameter int                  BSR_LEN    = 16,
   parameter logic [BSR_LEN-1:0]  UNBONDED   = 16'h0100,
   parameter int                  IR_W       = 3,
   parameter logic [IR_W-1:0]     INS_EXTEST = 3'b000,
   parameter logic [IR_W-1:0]     INS_IDCODE = 3'b001,
   parameter logic [IR_W-1:0]     INS_SAMPLE = 3'b100,
   parameter logic [IR_W-1:0]     INS_BYPASS = 3'b111,
   parameter logic [2:0]          ID_REV     = 3'b001,
   parameter logic [4:0]          ID_DEPTH   = 5'b01010,
   parameter logic [5:0]          ID_ARCH    = 6'b000000,
   parameter logic [5:0]          ID_DEVICE  = 6'b100101,
   parameter logic [10:0]         ID_VENDOR  = 11'b00000110100
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] bnd_pins,
   output logic               tdo,
   output logic               tdo_oe
);
   localparam logic [31:0] ID_VALUE = {ID_REV, ID_DEPTH, ID_ARCH, ID_DEVICE, ID_VENDOR, 1'b1};

   tap_state_t state;
   dr_path_t   path;
   logic       ir_so, dr_so;

   tap_fsm #(.RESET_RUN(5)) fsm_i (
      .tck(tck), .por_n(por_n), .tms(tms), .state(state)
   );

   tap_ir #(
      .IR_W(IR_W), .INS_EXTEST(INS_EXTEST), .INS_IDCODE(INS_IDCODE),
      .INS_SAMPLE(INS_SAMPLE), .INS_BYPASS(INS_BYPASS)
   ) ir_i (
      .tck(tck), .por_n(por_n), .tdi(tdi), .state(state),
      .ir_so(ir_so), .path(path)
   );

   tap_dr #(.BSR_LEN(BSR_LEN), .UNBONDED(UNBONDED), .ID_VALUE(ID_VALUE)) dr_i (
      .tck(tck), .por_n(por_n), .tdi(tdi), .state(state), .path(path),
      .bnd_pins(bnd_pins), .dr_so(dr_so)
   );

   wire shifting = (state == ST_SH_IR) || (state == ST_SH_DR);

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= shifting;
         tdo    <= shifting ? ((state == ST_SH_IR) ? ir_so : dr_so) : 1'b0;
      end
   end

   a_r11_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
      tdo_oe |-> shifting);

   a_r11_quiet_off_shift: assert property (@(posedge tck) disable iff (!por_n)
      !tdo_oe |-> !tdo);

endmodule

// File: tb/tap_port_tb_top.sv
`timescale 1ns/1ps
module tap_port_tb_top;
   logic        tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic [15:0] pins = 16'h0;
   logic        tdo, tdo_oe;
   int checks = 0, errors = 0;

   localparam logic [31:0] EXP_ID = {3'b001, 5'b01010, 6'b000000, 6'b100101, 11'b00000110100, 1'b1};
   localparam logic [15:0] MASK   = 16'h0100;

   localparam int S_RST=0, S_IDLE=1, S_SDR=2, S_CDR=3, S_SHDR=4, S_E1DR=5, S_PDR=6, S_E2DR=7,
                  S_UDR=8, S_SIR=9, S_CIR=10, S_SHIR=11, S_E1IR=12, S_PIR=13, S_E2IR=14, S_UIR=15;

   always #4 tck = ~tck;

   tap_port dut_i (.tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
                   .bnd_pins(pins), .tdo(tdo), .tdo_oe(tdo_oe));

   // reference model state
   int          m_st = S_RST;
   logic [2:0]  m_ir = 3'b001, m_ir_sr = 3'b001;
   logic [63:0] m_dr = '0;
   int          m_len = 1;

   function automatic int nxt(int s, bit m);
      case (s)
         S_RST:  return m ? S_RST  : S_IDLE;
         S_IDLE: return m ? S_SDR  : S_IDLE;
         S_SDR:  return m ? S_SIR  : S_CDR;
         S_CDR:  return m ? S_E1DR : S_SHDR;
         S_SHDR: return m ? S_E1DR : S_SHDR;
         S_E1DR: return m ? S_UDR  : S_PDR;
         S_PDR:  return m ? S_E2DR : S_PDR;
         S_E2DR: return m ? S_UDR  : S_SHDR;
         S_UDR:  return m ? S_SDR  : S_IDLE;
         S_SIR:  return m ? S_RST  : S_CIR;
         S_CIR:  return m ? S_E1IR : S_SHIR;
         S_SHIR: return m ? S_E1IR : S_SHIR;
         S_E1IR: return m ? S_UIR  : S_PIR;
         S_PIR:  return m ? S_E2IR : S_PIR;
         S_E2IR: return m ? S_UIR  : S_SHIR;
         default: return m ? S_SDR : S_IDLE;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge(input bit m, input bit d);
      case (m_st)
         S_RST:  m_ir = 3'b001;
         S_CIR:  m_ir_sr = 3'b001;
         S_SHIR: m_ir_sr = {d, m_ir_sr[2:1]};
         S_UIR:  m_ir = m_ir_sr;
         S_CDR: begin
            if (m_ir == 3'b001) begin
               m_dr = {32'h0, EXP_ID}; m_len = 32;
            end else if (m_ir == 3'b000 || m_ir == 3'b100) begin
               m_dr = {48'h0, pins | MASK}; m_len = 16;
            end else begin
               m_dr = '0; m_len = 1;
            end
         end
         S_SHDR: begin
            m_dr = m_dr >> 1;
            m_dr[m_len-1] = d;
         end
         default: ;
      endcase
      m_st = nxt(m_st, m);
   endtask

   // one clock: drive, check tdo holds across rising edge, compare after falling edge
   task automatic tick(input bit m, input bit d);
      logic prev;
      bit   e_oe;
      tms = m; tdi = d;
      prev = tdo;
      @(posedge tck);
      model_edge(m, d);
      #1 chk("R11 tdo held at rising edge", tdo, prev);
      @(negedge tck);
      #1;
      e_oe = (m_st == S_SHIR) || (m_st == S_SHDR);
      chk("R11 tdo_oe vs model", tdo_oe, e_oe);
      if (e_oe) chk("R11 tdo vs model", tdo, (m_st == S_SHIR) ? m_ir_sr[0] : m_dr[0]);
   endtask

   task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 3; i++) begin
         cap[i] = tdo;
         tick(i == 2, code[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
      dout = '0;
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         tick(i == n - 1, din[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] d;
      logic [2:0]  c;
      logic [2:0]  rsv [4] = '{3'b010, 3'b011, 3'b101, 3'b110};
      @(negedge tck); #1;
      chk("R11 tdo_oe low in reset", tdo_oe, 0);
      @(negedge tck); #1;
      por_n = 1'b1;
      tick(0, 0);

      // R2 / R5: identification after power-on
      scan_dr(64'h0, 32, d);
      chk("R2 id word after power-on", d[31:0], EXP_ID);
      chk("R5 id bit0", d[0], 1'b1);
      chk("R5 vendor field", d[11:1], 11'b00000110100);
      chk("R5 device field", d[17:12], 6'b100101);

      // R3 / R6: capture value and bypass
      scan_ir(3'b111, c);
      chk("R3 ir capture bits", c, 3'b001);
      scan_dr(64'hA5, 8, d);
      chk("R6 bypass one-cycle delay", d[7:0], 8'h4A);

      // R8 / R4: sample path takes effect after update
      scan_ir(3'b100, c);
      chk("R3 ir capture again", c, 3'b001);
      pins = 16'h3C0F;
      scan_dr(64'hFFFF, 16, d);
      chk("R4 R8 sample captures pins", d[15:0], 16'h3D0F);
      pins = 16'h0000;
      scan_dr(64'hFFFF, 16, d);
      chk("R8 update-dr under sample has no effect", d[15:0], 16'h0100);
      chk("R10 unbonded cell reads 1", d[8], 1'b1);

      // R9 / R10: external test
      scan_ir(3'b000, c);
      pins = 16'h5A5A;
      scan_dr(64'h0, 16, d);
      chk("R9 extest captures pins", d[15:0], 16'h5B5A);
      chk("R10 unbonded cell forced", d[8], 1'b1);

      // R7: unassigned codes act as bypass
      foreach (rsv[k]) begin
         scan_ir(rsv[k], c);
         scan_dr(64'hB, 4, d);
         chk("R7 reserved code bypasses", d[3:0], 4'h6);
      end

      // R1: escape from mid data shift
      scan_ir(3'b111, c);
      tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
      for (int i = 0; i < 5; i++) tick(1, 0);
      chk("R1 tdo_oe low after escape", tdo_oe, 0);
      tick(0, 0);
      scan_dr(64'h0, 32, d);
      chk("R1 id selected after escape", d[31:0], EXP_ID);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule